// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block is a synchronous controller that takes a display panel and its serial video link through a fixed power-up order and the exact reverse on power-down. It drives two supply enables (analog first, digital second), an active-low panel reset, a request that holds the link lanes in the LP11 idle state, and a lane-enable output. A one-cycle `on_req` starts the power-up. An `off_req` takes the outputs down in reverse, from whichever stage has been reached.

Every wait is a parameter given in clock cycles. The defaults match a 125 MHz clock: 1 ms supply gap, 10 ms power-good window, 2 ms reset-low dwell, 15 ms reset recovery, and 150 µs LP11 hold. The supply power-good input is asynchronous and passes through a synchroniser. If power-good does not arrive inside the window, the controller switches off in safe order and latches a fault flag. The flag stays set until the next request.

Top module: `panel_pwr_seq`

## Requirements
- R1: A synchronous reset puts every output low one edge later: both supply enables, `panel_rst_n`, `lp11_hold`, `lanes_en`, `busy`, `ready` and `fault`.
- R2: Power-up raises outputs in this order: `avdd_en`, then `dvdd_en`, then `panel_rst_n`, then `lp11_hold`, then `lanes_en`. None of them falls during power-up.
- R3: After `on_req` in the off state, `avdd_en` rises on the next edge and stays alone for exactly `T_AD_GAP` cycles. `dvdd_en` then rises.
- R4: Once both supplies are on, the controller waits for power-good. `pgood` passes through a `SYNC_STAGES`-flop synchroniser, so it is seen `SYNC_STAGES` cycles after it is driven. If it is not seen within `T_RAMP` cycles, the fault path of R9 is taken.
- R5: `panel_rst_n` stays low for exactly `T_RST_LOW` cycles after the cycle in which power-good is seen.
- R6: `lp11_hold` rises `T_RST_REC` cycles after `panel_rst_n` rises. `lanes_en` rises `T_LP11` cycles after `lp11_hold` rises.
- R7: `off_req` while lanes are on runs the steps below in order. Lanes drop first, then LP11 is held for `T_LP11` cycles and released. Reset stays high for another `T_LP11` cycles and then goes low. After `T_RST_LOW` cycles `dvdd_en` drops, and `T_AD_GAP` cycles later `avdd_en` drops.
- R8: `off_req` during power-up aborts it. On the next edge the matching shutdown step begins: from the analog-only stage, everything goes off; from power-good wait or reset-low, the `dvdd_en` drop step; from reset recovery, the reset-low step; from the LP11 stage, the LP11-release step.
- R9: On a power-good timeout, `fault` rises. At the same edge `dvdd_en` drops, and `T_AD_GAP` cycles later `avdd_en` drops. `fault` stays high in the off state until the next `on_req` or `off_req`, which clears it.
- R10: `ready` is high exactly while `lanes_en` is high. `busy` is high in every state other than fully off and fully on.
- R11: `on_req` has no effect while fully on or during power-down. `off_req` has no effect on the outputs while fully off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| on_req | input | 1 | Power-up request pulse |
| off_req | input | 1 | Power-down request pulse, wins over on_req |
| pgood | input | 1 | Asynchronous supply power-good |
| avdd_en | output | 1 | Analog supply enable |
| dvdd_en | output | 1 | Digital supply enable |
| panel_rst_n | output | 1 | Panel reset, active low |
| lp11_hold | output | 1 | Request to hold lanes in LP11 idle |
| lanes_en | output | 1 | Clock and data lane enable |
| busy | output | 1 | Timed transition in progress |
| ready | output | 1 | Lanes enabled |
| fault | output | 1 | Power-good timeout latched |

## Verification
All outputs are flops loaded from the next-state decode, so a request driven in one cycle changes the outputs at the very next edge. Every timed stage then lasts exactly its parameter count in cycles. A `pgood` change adds the synchroniser depth plus one edge before the next stage appears. The bench drives inputs and samples outputs on falling edges. After each request pulse, it checks every stage's full output pattern on each cycle for the number of cycles the requirement gives. This exposes any one-cycle shift in a dwell, an abort target or the synchroniser latency.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_AVDD,
        ST_PGWAIT,
        ST_RSTLOW,
        ST_RSTREC,
        ST_LP11,
        ST_ON,
        ST_DN_LANES,
        ST_DN_LP11,
        ST_DN_RST,
        ST_DN_DVDD
    } seq_state_e;

    typedef struct packed {
        logic avdd;
        logic dvdd;
        logic rst_n;
        logic lp11;
        logic lanes;
    } rail_t;

    typedef struct packed {
        seq_state_e st;
        logic       fault;
        rail_t      rails;
        logic       busy;
        logic       ready;
    } seq_regs_t;

    // Output levels held in each stage.
    function automatic rail_t rails_of(seq_state_e s);
        rail_t r;
        r = '0;
        case (s)
            ST_AVDD:                 r = '{avdd: 1'b1, dvdd: 1'b0, rst_n: 1'b0, lp11: 1'b0, lanes: 1'b0};
            ST_PGWAIT, ST_RSTLOW,
            ST_DN_RST:               r = '{avdd: 1'b1, dvdd: 1'b1, rst_n: 1'b0, lp11: 1'b0, lanes: 1'b0};
            ST_RSTREC, ST_DN_LP11:   r = '{avdd: 1'b1, dvdd: 1'b1, rst_n: 1'b1, lp11: 1'b0, lanes: 1'b0};
            ST_LP11, ST_DN_LANES:    r = '{avdd: 1'b1, dvdd: 1'b1, rst_n: 1'b1, lp11: 1'b1, lanes: 1'b0};
            ST_ON:                   r = '{avdd: 1'b1, dvdd: 1'b1, rst_n: 1'b1, lp11: 1'b1, lanes: 1'b1};
            ST_DN_DVDD:              r = '{avdd: 1'b1, dvdd: 1'b0, rst_n: 1'b0, lp11: 1'b0, lanes: 1'b0};
            default:                 r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= {sh_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pps_dwell_timer.sv
module pps_dwell_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart)             cnt_d = '0;
        else if (cnt_q != '1)    cnt_d = cnt_q + CNT_W'(1);
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // Last cycle of a dwell of `limit` cycles.
    assign expired = (cnt_q == limit - CNT_W'(1));
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
    import pps_pkg::*;
#(
    parameter int unsigned T_AD_GAP    = 125000,
    parameter int unsigned T_RAMP      = 1250000,
    parameter int unsigned T_RST_LOW   = 250000,
    parameter int unsigned T_RST_REC   = 1875000,
    parameter int unsigned T_LP11      = 18750,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic on_req,
    input  logic off_req,
    input  logic pgood,
    output logic avdd_en,
    output logic dvdd_en,
    output logic panel_rst_n,
    output logic lp11_hold,
    output logic lanes_en,
    output logic busy,
    output logic ready,
    output logic fault
);
    localparam int unsigned M1    = (T_AD_GAP  > T_RAMP)    ? T_AD_GAP  : T_RAMP;
    localparam int unsigned M2    = (T_RST_LOW > T_RST_REC) ? T_RST_LOW : T_RST_REC;
    localparam int unsigned M3    = (M1 > M2) ? M1 : M2;
    localparam int unsigned T_MAX = (M3 > T_LP11) ? M3 : T_LP11;
    localparam int unsigned CNT_W = $clog2(T_MAX + 1);

    localparam seq_regs_t SEQ_RST = '{st: ST_OFF, fault: 1'b0, rails: '0,
                                      busy: 1'b0, ready: 1'b0};

    seq_regs_t        seq_d, seq_q;
    logic             pg_s;
    logic             tmr_restart;
    logic             tmr_expired;
    logic [CNT_W-1:0] tmr_limit;

    pps_sync #(.STAGES(SYNC_STAGES)) i_pg_sync (
        .clk (clk),
        .rst (rst),
        .d   (pgood),
        .q   (pg_s)
    );

    always_comb begin
        case (seq_q.st)
            ST_AVDD, ST_DN_DVDD:             tmr_limit = CNT_W'(T_AD_GAP);
            ST_PGWAIT:                       tmr_limit = CNT_W'(T_RAMP);
            ST_RSTLOW, ST_DN_RST:            tmr_limit = CNT_W'(T_RST_LOW);
            ST_RSTREC:                       tmr_limit = CNT_W'(T_RST_REC);
            ST_LP11, ST_DN_LANES, ST_DN_LP11: tmr_limit = CNT_W'(T_LP11);
            default:                         tmr_limit = CNT_W'(1);
        endcase
    end

    pps_dwell_timer #(.CNT_W(CNT_W)) i_dwell (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_restart),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_OFF: begin
                if (on_req || off_req) seq_d.fault = 1'b0;
                if (on_req && !off_req) seq_d.st = ST_AVDD;
            end
            ST_AVDD: begin
                if (off_req)          seq_d.st = ST_OFF;
                else if (tmr_expired) seq_d.st = ST_PGWAIT;
            end
            ST_PGWAIT: begin
                if (off_req)          seq_d.st = ST_DN_DVDD;
                else if (pg_s)        seq_d.st = ST_RSTLOW;
                else if (tmr_expired) begin
                    seq_d.st    = ST_DN_DVDD;
                    seq_d.fault = 1'b1;
                end
            end
            ST_RSTLOW: begin
                if (off_req)          seq_d.st = ST_DN_DVDD;
                else if (tmr_expired) seq_d.st = ST_RSTREC;
            end
            ST_RSTREC: begin
                if (off_req)          seq_d.st = ST_DN_RST;
                else if (tmr_expired) seq_d.st = ST_LP11;
            end
            ST_LP11: begin
                if (off_req)          seq_d.st = ST_DN_LP11;
                else if (tmr_expired) seq_d.st = ST_ON;
            end
            ST_ON: begin
                if (off_req)          seq_d.st = ST_DN_LANES;
            end
            ST_DN_LANES: if (tmr_expired) seq_d.st = ST_DN_LP11;
            ST_DN_LP11:  if (tmr_expired) seq_d.st = ST_DN_RST;
            ST_DN_RST:   if (tmr_expired) seq_d.st = ST_DN_DVDD;
            ST_DN_DVDD:  if (tmr_expired) seq_d.st = ST_OFF;
            default:     seq_d.st = ST_OFF;
        endcase
        seq_d.rails = rails_of(seq_d.st);
        seq_d.busy  = (seq_d.st != ST_OFF) && (seq_d.st != ST_ON);
        seq_d.ready = (seq_d.st == ST_ON);
    end

    assign tmr_restart = (seq_d.st != seq_q.st);

    always_ff @(posedge clk) begin
        if (rst) seq_q <= SEQ_RST;
        else     seq_q <= seq_d;
    end

    assign avdd_en     = seq_q.rails.avdd;
    assign dvdd_en     = seq_q.rails.dvdd;
    assign panel_rst_n = seq_q.rails.rst_n;
    assign lp11_hold   = seq_q.rails.lp11;
    assign lanes_en    = seq_q.rails.lanes;
    assign busy        = seq_q.busy;
    assign ready       = seq_q.ready;
    assign fault       = seq_q.fault;
endmodule

// File: rtl/pps_checker.sv
module pps_checker (
    input logic clk,
    input logic rst,
    input logic avdd_en,
    input logic dvdd_en,
    input logic panel_rst_n,
    input logic lp11_hold,
    input logic lanes_en,
    input logic busy,
    input logic ready,
    input logic fault
);
    a_r1_reset_all_off: assert property (@(posedge clk)
        rst |=> (!avdd_en && !dvdd_en && !panel_rst_n && !lp11_hold
                 && !lanes_en && !busy && !ready && !fault));

    a_r2_dvdd_needs_avdd: assert property (@(posedge clk) disable iff (rst)
        dvdd_en |-> avdd_en);

    a_r2_rst_high_needs_supplies: assert property (@(posedge clk) disable iff (rst)
        panel_rst_n |-> (avdd_en && dvdd_en));

    a_r2_lanes_need_all: assert property (@(posedge clk) disable iff (rst)
        lanes_en |-> (lp11_hold && panel_rst_n && dvdd_en && avdd_en));

    a_r3_dvdd_after_avdd: assert property (@(posedge clk) disable iff (rst)
        $rose(dvdd_en) |-> $past(avdd_en));

    a_r7_lanes_off_before_lp11: assert property (@(posedge clk) disable iff (rst)
        $fell(lp11_hold) |-> $past(!lanes_en));

    a_r9_fault_rise_safe: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> (!dvdd_en && !panel_rst_n && !lanes_en));

    a_r10_ready_is_lanes: assert property (@(posedge clk) disable iff (rst)
        ready == lanes_en);

    a_r10_ready_not_busy: assert property (@(posedge clk) disable iff (rst)
        !(ready && busy));
endmodule

bind panel_pwr_seq pps_checker i_pps_checker (
    .clk         (clk),
    .rst         (rst),
    .avdd_en     (avdd_en),
    .dvdd_en     (dvdd_en),
    .panel_rst_n (panel_rst_n),
    .lp11_hold   (lp11_hold),
    .lanes_en    (lanes_en),
    .busy        (busy),
    .ready       (ready),
    .fault       (fault)
);

// File: tb/test_panel_pwr_seq.sv
module test_panel_pwr_seq;
    localparam int TB_AD = 3;
    localparam int TB_RP = 8;
    localparam int TB_RL = 4;
    localparam int TB_RR = 6;
    localparam int TB_LP = 5;

    // Observed pattern {avdd,dvdd,rst_n,lp11,lanes,busy,ready,fault}.
    localparam logic [7:0] P_OFF   = 8'b0000_0000;
    localparam logic [7:0] P_OFF_F = 8'b0000_0001;
    localparam logic [7:0] P_AVDD  = 8'b1000_0100;
    localparam logic [7:0] P_AVD_F = 8'b1000_0101;
    localparam logic [7:0] P_RSTLO = 8'b1100_0100;
    localparam logic [7:0] P_RSTHI = 8'b1110_0100;
    localparam logic [7:0] P_LP11  = 8'b1111_0100;
    localparam logic [7:0] P_ON    = 8'b1111_1010;

    // {pattern, cycles, requirement number}
    localparam logic [23:0] UP_TBL [5] = '{
        {P_AVDD,  8'(TB_AD),     8'd3},   // R3 analog alone
        {P_RSTLO, 8'(1 + TB_RL), 8'd5},   // R5 pgood seen + reset low dwell
        {P_RSTHI, 8'(TB_RR),     8'd6},   // R6 reset recovery
        {P_LP11,  8'(TB_LP),     8'd6},   // R6 LP11 hold
        {P_ON,    8'd4,          8'd10}   // R10 ready with lanes
    };
    localparam logic [23:0] DN_TBL [5] = '{
        {P_LP11,  8'(TB_LP), 8'd7},       // R7 lanes off first
        {P_RSTHI, 8'(TB_LP), 8'd7},       // R7 LP11 released
        {P_RSTLO, 8'(TB_RL), 8'd7},       // R7 reset low
        {P_AVDD,  8'(TB_AD), 8'd7},       // R7 digital off before analog
        {P_OFF,   8'd3,      8'd7}        // R7 all off
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic on_req = 1'b0;
    logic off_req = 1'b0;
    logic pgood = 1'b1;
    logic avdd_en, dvdd_en, panel_rst_n, lp11_hold, lanes_en, busy, ready, fault;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    panel_pwr_seq #(
        .T_AD_GAP(TB_AD), .T_RAMP(TB_RP), .T_RST_LOW(TB_RL),
        .T_RST_REC(TB_RR), .T_LP11(TB_LP), .SYNC_STAGES(2)
    ) i_panel_pwr_seq (
        .clk(clk), .rst(rst), .on_req(on_req), .off_req(off_req), .pgood(pgood),
        .avdd_en(avdd_en), .dvdd_en(dvdd_en), .panel_rst_n(panel_rst_n),
        .lp11_hold(lp11_hold), .lanes_en(lanes_en), .busy(busy),
        .ready(ready), .fault(fault)
    );

    wire [7:0] obs = {avdd_en, dvdd_en, panel_rst_n, lp11_hold, lanes_en, busy, ready, fault};

    // Samples the current falling edge and the following ones; ends on the
    // falling edge after the last sample.
    task automatic expect_hold(input logic [7:0] pat, input int dur, input string req);
        bit bad = 1'b0;
        for (int k = 0; k < dur; k++) begin
            if (!bad && obs !== pat) begin
                $display("FAIL %s cycle %0d: actual %b expected %b", req, k, obs, pat);
                bad = 1'b1;
            end
            @(negedge clk);
        end
        checks++;
        if (bad) failures++;
    endtask

    task automatic pulse_on();
        on_req = 1'b1;
        @(negedge clk);
        on_req = 1'b0;
    endtask

    task automatic pulse_off();
        off_req = 1'b1;
        @(negedge clk);
        off_req = 1'b0;
    endtask

    task automatic walk(input logic [23:0] e);
        expect_hold(e[23:16], int'(e[15:8]), $sformatf("R%0d", e[7:0]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_hold(P_OFF, 2, "R1");                 // R1 held in reset
        rst = 1'b0;
        @(negedge clk);
        expect_hold(P_OFF, 2, "R1");

        pulse_off();                                 // R11 off while off
        expect_hold(P_OFF, 3, "R11");

        // Full power-up and power-down from the table (R2..R7, R10)
        pulse_on();
        foreach (UP_TBL[i]) walk(UP_TBL[i]);
        pulse_on();                                  // R11 on while on
        expect_hold(P_ON, 3, "R11");
        pulse_off();
        foreach (DN_TBL[i]) walk(DN_TBL[i]);

        // R9 power-good timeout
        pgood = 1'b0;
        repeat (3) @(negedge clk);
        pulse_on();
        expect_hold(P_AVDD,  TB_AD, "R3");
        expect_hold(P_RSTLO, TB_RP, "R4");
        expect_hold(P_AVD_F, TB_AD, "R9");
        expect_hold(P_OFF_F, 4,     "R9");

        // R9 clear on request; R4 synchroniser latency; R8 abort in recovery
        pulse_on();
        expect_hold(P_AVDD,  TB_AD, "R9");
        expect_hold(P_RSTLO, 2,     "R4");
        pgood = 1'b1;
        expect_hold(P_RSTLO, 3 + TB_RL, "R4");
        expect_hold(P_RSTHI, 2,     "R6");
        pulse_off();
        expect_hold(P_RSTLO, TB_RL, "R8");
        expect_hold(P_AVDD,  TB_AD, "R8");
        expect_hold(P_OFF,   3,     "R8");

        // R8 abort during analog-only stage
        pulse_on();
        expect_hold(P_AVDD, 1, "R8");
        pulse_off();
        expect_hold(P_OFF, 3, "R8");

        // R8 abort during LP11 stage
        pulse_on();
        expect_hold(P_AVDD,  TB_AD,     "R8");
        expect_hold(P_RSTLO, 1 + TB_RL, "R8");
        expect_hold(P_RSTHI, TB_RR,     "R8");
        expect_hold(P_LP11,  2,         "R8");
        pulse_off();
        expect_hold(P_RSTHI, TB_LP, "R8");
        expect_hold(P_RSTLO, TB_RL, "R8");
        expect_hold(P_AVDD,  TB_AD, "R8");
        expect_hold(P_OFF,   2,     "R8");

        // R11 on request during power-down is ignored
        pulse_on();
        foreach (UP_TBL[i]) walk(UP_TBL[i]);
        pulse_off();
        expect_hold(P_LP11, 2, "R11");
        pulse_on();
        expect_hold(P_LP11,  TB_LP - 3, "R11");
        expect_hold(P_RSTHI, TB_LP, "R11");
        expect_hold(P_RSTLO, TB_RL, "R11");
        expect_hold(P_AVDD,  TB_AD, "R11");
        expect_hold(P_OFF,   3,     "R11");

        // R1 synchronous reset while fully on
        pulse_on();
        foreach (UP_TBL[i]) walk(UP_TBL[i]);
        rst = 1'b1;
        @(negedge clk);
        expect_hold(P_OFF, 2, "R1");
        rst = 1'b0;
        @(negedge clk);
        expect_hold(P_OFF, 2, "R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule